// File: doc/BRIEF.md
# Cascaded Upper-Word Counter-Timer

This block is the upper half of a double-width counter-timer made from two cascaded counters. A partner counter holds the lower word. The upper word steps once for each wrap of the lower word. The partner reports a wrap by raising `strobe_in` during the cycle just before its own wrap edge, so that both halves change on the same clock edge. The upper word keeps its own limit value, and it raises `stopped` once its own end condition has been reached. The partner may halt or reload at its own limit only while `stopped` is high. The block's run bit is sent to the partner on `en_out`, so the lower half runs only while the upper half runs.

Software sees three registers through a simple write port with byte enables and a combinational read port. The registers are control, limit and count. With chaining switched off, the block is a standalone timer that steps on every clock. The partner drives `offset_in` high when the pair counts up and the lower limit is zero. Both halves then wrap on the same edge, and the upper word moves its stop compare one count earlier so that `stopped` is already high at that moment.

Top module: `chained_hi_timer`

## Requirements
- R1: After reset, control, limit and count read as zero, and `stopped`, `irq` and `en_out` are low.
- R2: Control register fields are run (bit 0), one-shot (bit 1, 1 = one-shot, 0 = continuous), up (bit 2, 1 = up, 0 = down), chain (bit 3) and interrupt enable (bit 4). Bits above 4 read as zero. `en_out` follows the run bit. Register select codes are 0 = control, 1 = limit, 2 = count.
- R3: Limit and count take byte-lane writes: lane k covers bits 8k+7..8k. A count write wins over counting in the same cycle. Control is written only when lane 0 is enabled.
- R4: On the first clock that finds run newly set, the count loads zero when counting up, or the limit when counting down, and `stopped` clears.
- R5: With chain set, the count changes by one step only on edges where `strobe_in` is high.
- R6: With chain clear, the count steps on every clock while running, and `strobe_in` is ignored.
- R7: In continuous mode, a step taken at the end value reloads the count: zero after reaching the limit when counting up, the limit after reaching zero when counting down.
- R8: In one-shot mode, a step taken at the end value leaves the count unchanged, and once `stopped` is set it stays high until the next start.
- R9: `stopped` becomes high one clock after the count equals the stop target. The target is the limit when counting up and zero when counting down.
- R10: With chain set, up-counting and `offset_in` high, the stop target is the limit minus one. In down mode or unchained, `offset_in` has no effect.
- R11: `irq` is a one-cycle pulse in the cycle after `stopped` rises, and only when interrupt enable is set.
- R12: While run is clear, the count and `stopped` hold their values.
- R13: Chained with a lower-word partner, the combined value {count, lower} follows a double-width reference counter: 0 up to the combined limit and back to 0 when counting up with a zero lower limit, or from the combined limit down to 0 and back when counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for write |
| wr_be | input | W/8 | Byte-lane enables for write |
| wr_data | input | W | Write data |
| rd_addr | input | 2 | Register select for read |
| rd_data | output | W | Read data (combinational) |
| strobe_in | input | 1 | Lower word wraps on the coming edge |
| offset_in | input | 1 | Lower limit is zero while counting up |
| en_out | output | 1 | Run enable to the lower word |
| stopped | output | 1 | Upper word has reached its stop target |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions check these properties on every cycle: a chained count stays put when no strobe comes, the count and `stopped` hold while run is clear, an unchained match sets `stopped` on the next edge, a one-shot stop holds, and `irq` is a single pulse that follows a raised `stopped`. Other behaviour can only be shown by the bench's directed scenarios. These include the exact count sequences across continuous wraps, the start values in each direction, byte-lane merging and write priority, and `offset_in` being ignored when unchained or counting down. They also include the double-width agreement with a behavioural lower word, in both directions, where the one-count earlier compare is what makes the zero-lower-limit case work.

// File: rtl/hwc_pkg.sv
`timescale 1ns/1ps
package hwc_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_COUNT = 2'd2
    } reg_sel_e;

    localparam int CTRL_BITS = 5;

    // packed MSB first: irq_en is bit 4, run is bit 0
    typedef struct packed {
        logic irq_en;
        logic chain;
        logic up;
        logic oneshot;
        logic run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_bits(input logic [CTRL_BITS-1:0] b);
        return ctrl_t'(b);
    endfunction

    function automatic logic [CTRL_BITS-1:0] ctrl_to_bits(input ctrl_t c);
        return c;
    endfunction

endpackage

// File: rtl/hwc_lane_reg.sv
`timescale 1ns/1ps
module hwc_lane_reg #(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W/8-1:0]   we,
    input  logic [W-1:0]     d,
    output logic [W-1:0]     q
);
    localparam int NB = W / 8;

    logic [W-1:0] merged;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign merged[g*8 +: 8] = we[g] ? d[g*8 +: 8] : q[g*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= merged;
    end
endmodule

// File: rtl/hwc_ctrl_regs.sv
`timescale 1ns/1ps
module hwc_ctrl_regs import hwc_pkg::*; #(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_wr,
    input  logic [CTRL_BITS-1:0] ctrl_data,
    input  logic [W/8-1:0]       limit_we,
    input  logic [W-1:0]         wr_data,
    output ctrl_t                ctrl,
    output logic [W-1:0]         limit
);
    always_ff @(posedge clk) begin
        if (rst)          ctrl <= '0;
        else if (ctrl_wr) ctrl <= ctrl_from_bits(ctrl_data);
    end

    hwc_lane_reg #(.W(W)) u_limit (
        .clk (clk),
        .rst (rst),
        .we  (limit_we),
        .d   (wr_data),
        .q   (limit)
    );
endmodule

// File: rtl/hwc_core.sv
`timescale 1ns/1ps
module hwc_core import hwc_pkg::*; #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  ctrl_t          ctrl,
    input  logic [W-1:0]   limit,
    input  logic [W/8-1:0] cnt_we,
    input  logic [W-1:0]   wr_data,
    input  logic           strobe_in,
    input  logic           offset_in,
    output logic [W-1:0]   count,
    output logic           stopped,
    output logic           prev_run
);
    localparam int          NB  = W / 8;
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] merged;
    logic [W-1:0] stepped;
    logic [W-1:0] wrap_val;
    logic [W-1:0] stop_tgt;
    logic         step;
    logic         at_end;
    logic         any_wr;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign merged[g*8 +: 8] = cnt_we[g] ? wr_data[g*8 +: 8] : count[g*8 +: 8];
    end

    always_comb begin
        any_wr   = |cnt_we;
        step     = !ctrl.chain || strobe_in;
        at_end   = ctrl.up ? (count == limit) : (count == '0);
        wrap_val = ctrl.up ? '0 : limit;
        stepped  = ctrl.up ? (count + ONE) : (count - ONE);
        if (!ctrl.up)                     stop_tgt = '0;
        else if (ctrl.chain && offset_in) stop_tgt = limit - ONE;
        else                              stop_tgt = limit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            stopped  <= 1'b0;
            prev_run <= 1'b0;
        end else begin
            prev_run <= ctrl.run;
            if (any_wr) begin
                count <= merged;
            end else if (ctrl.run) begin
                if (!prev_run) begin
                    count   <= wrap_val;
                    stopped <= 1'b0;
                end else begin
                    if (step) begin
                        if (!at_end)           count <= stepped;
                        else if (!ctrl.oneshot) count <= wrap_val;
                    end
                    stopped <= (ctrl.oneshot && stopped) || (count == stop_tgt);
                end
            end
        end
    end
endmodule

// File: rtl/hwc_irq.sv
`timescale 1ns/1ps
module hwc_irq (
    input  logic clk,
    input  logic rst,
    input  logic irq_en,
    input  logic stopped,
    output logic irq
);
    logic stopped_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stopped_q <= 1'b0;
            irq       <= 1'b0;
        end else begin
            stopped_q <= stopped;
            irq       <= irq_en && stopped && !stopped_q;
        end
    end
endmodule

// File: rtl/chained_hi_timer.sv
`timescale 1ns/1ps
module chained_hi_timer import hwc_pkg::*; #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [W/8-1:0] wr_be,
    input  logic [W-1:0]   wr_data,
    input  logic [1:0]     rd_addr,
    output logic [W-1:0]   rd_data,
    input  logic           strobe_in,
    input  logic           offset_in,
    output logic           en_out,
    output logic           stopped,
    output logic           irq
);
    localparam int NB = W / 8;

    ctrl_t           ctrl;
    logic [W-1:0]    limit;
    logic [W-1:0]    count;
    logic            prev_run;
    logic            ctrl_wr;
    logic [NB-1:0]   limit_we;
    logic [NB-1:0]   cnt_we;
    logic            cnt_wr;

    assign ctrl_wr  = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL) && wr_be[0];
    assign limit_we = (wr_en && (reg_sel_e'(wr_addr) == SEL_LIMIT)) ? wr_be : '0;
    assign cnt_we   = (wr_en && (reg_sel_e'(wr_addr) == SEL_COUNT)) ? wr_be : '0;
    assign cnt_wr   = |cnt_we;

    hwc_ctrl_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (wr_data[CTRL_BITS-1:0]),
        .limit_we  (limit_we),
        .wr_data   (wr_data),
        .ctrl      (ctrl),
        .limit     (limit)
    );

    hwc_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .limit     (limit),
        .cnt_we    (cnt_we),
        .wr_data   (wr_data),
        .strobe_in (strobe_in),
        .offset_in (offset_in),
        .count     (count),
        .stopped   (stopped),
        .prev_run  (prev_run)
    );

    hwc_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .irq_en  (ctrl.irq_en),
        .stopped (stopped),
        .irq     (irq)
    );

    assign en_out = ctrl.run;

    always_comb begin
        case (reg_sel_e'(rd_addr))
            SEL_CTRL:  rd_data = {{(W-CTRL_BITS){1'b0}}, ctrl_to_bits(ctrl)};
            SEL_LIMIT: rd_data = limit;
            SEL_COUNT: rd_data = count;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/chained_hi_timer_chk.sv
`timescale 1ns/1ps
module chained_hi_timer_chk import hwc_pkg::*; #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input ctrl_t        ctrl,
    input logic [W-1:0] limit,
    input logic [W-1:0] count,
    input logic         prev_run,
    input logic         stopped,
    input logic         irq,
    input logic         strobe_in,
    input logic         cnt_wr,
    input logic         en_out
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0 && !stopped && !irq && !en_out));

    // R5
    chain_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.chain && ctrl.run && prev_run && !strobe_in && !cnt_wr) |=> $stable(count));

    // R12
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cnt_wr) |=> ($stable(count) && $stable(stopped)));

    // R9
    stop_after_match_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && prev_run && !ctrl.chain && !cnt_wr
         && count == (ctrl.up ? limit : '0)) |=> stopped);

    // R8
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && prev_run && ctrl.oneshot && !ctrl.chain && stopped && !cnt_wr
         && count == (ctrl.up ? limit : '0)) |=> (stopped && $stable(count)));

    // R11
    irq_follows_stop_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(stopped) && $past(ctrl.irq_en)));

    // R11
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
endmodule

bind chained_hi_timer chained_hi_timer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .limit     (limit),
    .count     (count),
    .prev_run  (prev_run),
    .stopped   (stopped),
    .irq       (irq),
    .strobe_in (strobe_in),
    .cnt_wr    (cnt_wr),
    .en_out    (en_out)
);

// File: tb/chained_hi_timer_bench.sv
`timescale 1ns/1ps
module chained_hi_timer_bench;
    import hwc_pkg::*;

    localparam int W  = 32;
    localparam int NB = W / 8;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [1:0]    wr_addr;
    logic [NB-1:0] wr_be;
    logic [W-1:0]  wr_data;
    logic [1:0]    rd_addr;
    logic [W-1:0]  rd_data;
    logic          strobe_in;
    logic          offset_in;
    logic          en_out;
    logic          stopped;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    // behavioural lower word
    logic [LW-1:0] lo;
    logic [LW-1:0] lo_lim;
    logic          lo_prev, lo_up, lo_one, model_on, man_strobe;
    logic          lo_at_stop, model_strobe;

    assign lo_at_stop   = stopped && (lo_up ? (lo == lo_lim) : (lo == '0));
    assign model_strobe = en_out && lo_prev &&
                          (lo_at_stop ? !lo_one : (lo_up ? (lo == '1) : (lo == '0)));
    assign strobe_in    = model_on ? model_strobe : man_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo      <= '0;
            lo_prev <= 1'b0;
        end else begin
            lo_prev <= en_out;
            if (en_out) begin
                if (!lo_prev)        lo <= lo_up ? '0 : lo_lim;
                else if (lo_at_stop) lo <= lo_one ? lo : (lo_up ? '0 : lo_lim);
                else                 lo <= lo_up ? lo + 1'b1 : lo - 1'b1;
            end
        end
    end

    chained_hi_timer #(.W(W)) u_chained_hi_timer (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .strobe_in (strobe_in),
        .offset_in (offset_in),
        .en_out    (en_out),
        .stopped   (stopped),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [NB-1:0] be, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        rd(SEL_CTRL, v);  chk("R1 ctrl", 64'(v), 64'h0);
        rd(SEL_LIMIT, v); chk("R1 limit", 64'(v), 64'h0);
        rd(SEL_COUNT, v); chk("R1 count", 64'(v), 64'h0);
        chk("R1 stopped/irq/en_out", {61'h0, stopped, irq, en_out}, 64'h0);
    endtask

    task automatic t_regs;
        logic [W-1:0] v;
        wr(SEL_LIMIT, 4'b0101, 32'hAABBCCDD);
        rd(SEL_LIMIT, v); chk("R3 limit lanes", 64'(v), 64'h00BB00DD);
        wr(SEL_COUNT, 4'b1010, 32'h11223344);
        rd(SEL_COUNT, v); chk("R3 count lanes", 64'(v), 64'h11003300);
        wr(SEL_CTRL, 4'b1111, 32'hFFFFFFFE);
        rd(SEL_CTRL, v); chk("R2 ctrl fields", 64'(v), 64'h1E);
        chk("R2 en_out off", 64'(en_out), 64'h0);
        wr(SEL_CTRL, 4'b1110, 32'h00000001);
        rd(SEL_CTRL, v); chk("R3 ctrl lane0 needed", 64'(v), 64'h1E);
        wr(SEL_CTRL, 4'b0001, 32'h0);
    endtask

    // unchained up, continuous, irq enabled, offset_in held high
    task automatic t_up_cont;
        logic [W-1:0] v;
        logic [W-1:0] exp_c [7] = '{0, 1, 2, 3, 0, 1, 2};
        logic         exp_s [7] = '{0, 0, 0, 0, 1, 0, 0};
        logic         exp_i [7] = '{0, 0, 0, 0, 0, 1, 0};
        offset_in = 1'b1;
        wr(SEL_LIMIT, '1, 32'd3);
        wr(SEL_CTRL, 4'b0001, 32'h15);
        chk("R2 en_out on", 64'(en_out), 64'h1);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            rd(SEL_COUNT, v);
            chk("R4 R6 R7 count", 64'(v), 64'(exp_c[i]));
            chk("R9 R10 stopped", 64'(stopped), 64'(exp_s[i]));
            chk("R11 irq", 64'(irq), 64'(exp_i[i]));
        end
        offset_in = 1'b0;
        wr(SEL_CTRL, 4'b0001, 32'h0);
    endtask

    // unchained down, one-shot, no irq
    task automatic t_down_once;
        logic [W-1:0] v;
        logic [W-1:0] exp_c [6] = '{2, 1, 0, 0, 0, 0};
        logic         exp_s [6] = '{0, 0, 0, 1, 1, 1};
        wr(SEL_LIMIT, '1, 32'd2);
        wr(SEL_CTRL, 4'b0001, 32'h03);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rd(SEL_COUNT, v);
            chk("R4 R8 count", 64'(v), 64'(exp_c[i]));
            chk("R8 R9 stopped", 64'(stopped), 64'(exp_s[i]));
            chk("R11 no irq when disabled", 64'(irq), 64'h0);
        end
        wr(SEL_CTRL, 4'b0001, 32'h0);
    endtask

    // write priority and hold while stopped
    task automatic t_prio_hold;
        logic [W-1:0] v, v2;
        wr(SEL_LIMIT, '1, 32'd100);
        wr(SEL_CTRL, 4'b0001, 32'h05);
        repeat (4) @(negedge clk);
        wr(SEL_COUNT, '1, 32'd50);
        rd(SEL_COUNT, v); chk("R3 write beats count", 64'(v), 64'd50);
        @(negedge clk);
        rd(SEL_COUNT, v); chk("R6 resumes after write", 64'(v), 64'd51);
        wr(SEL_CTRL, 4'b0001, 32'h04);
        rd(SEL_COUNT, v);
        repeat (5) @(negedge clk);
        rd(SEL_COUNT, v2); chk("R12 hold while off", 64'(v2), 64'(v));
    endtask

    // manual strobes, chained
    task automatic t_chain_step;
        logic [W-1:0] v;
        model_on = 1'b0; man_strobe = 1'b0;
        wr(SEL_LIMIT, '1, 32'd1000);
        wr(SEL_CTRL, 4'b0001, 32'h0D);
        @(negedge clk);
        rd(SEL_COUNT, v); chk("R5 start", 64'(v), 64'd0);
        repeat (4) @(negedge clk);
        rd(SEL_COUNT, v); chk("R5 no strobe no step", 64'(v), 64'd0);
        man_strobe = 1'b1;
        @(negedge clk);
        man_strobe = 1'b0;
        rd(SEL_COUNT, v); chk("R5 one step", 64'(v), 64'd1);
        repeat (3) @(negedge clk);
        rd(SEL_COUNT, v); chk("R5 held", 64'(v), 64'd1);
        wr(SEL_CTRL, 4'b0001, 32'h0);
        model_on = 1'b1;
    endtask

    // chained double-width runs against a reference counter
    task automatic t_chain_run(input logic up, input logic [W-1:0] hi_lim,
                               input logic [LW-1:0] low_lim, input int cycles);
        logic [W-1:0] v;
        logic [63:0]  s, r;
        int           bad;
        s = (64'(hi_lim) << LW) | 64'(low_lim);
        lo_up = up; lo_lim = low_lim; lo_one = 1'b0;
        offset_in = 1'b1; // up with zero lower limit; ignored in down (R10)
        wr(SEL_LIMIT, '1, hi_lim);
        wr(SEL_CTRL, 4'b0001, up ? 32'h0D : 32'h09);
        r = up ? 64'h0 : s;
        bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            rd(SEL_COUNT, v);
            if (((64'(v) << LW) | 64'(lo)) !== r) begin
                bad++;
                if (bad == 1)
                    chk(up ? "R13 R10 up combined" : "R13 R10 down combined",
                        (64'(v) << LW) | 64'(lo), r);
            end
            if (up) r = (r == s) ? 64'h0 : r + 1;
            else    r = (r == 64'h0) ? s : r - 1;
        end
        if (bad == 0) chk(up ? "R13 up run" : "R13 down run", 64'h0, 64'h0);
        offset_in = 1'b0;
        wr(SEL_CTRL, 4'b0001, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_be = '0; wr_data = '0;
        rd_addr = '0; offset_in = 1'b0; man_strobe = 1'b0; model_on = 1'b1;
        lo_up = 1'b1; lo_lim = '0; lo_one = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_up_cont();
        t_down_once();
        t_prio_hold();
        wr(SEL_CTRL, 4'b0001, 32'h0);
        t_chain_step();
        t_chain_run(1'b1, 32'd2, 4'd0, 80);
        t_chain_run(1'b0, 32'd1, 4'd3, 60);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule